// File: doc/BRIEF.md
# Peripheral Interrupt Mask and Status Controller

This block gathers 32 peripheral interrupt lines into a single interrupt request for a processor. Software programs an enable mask and reads a status word over a small register bus with read and write strobes, a byte address, write data and registered read data. The request output is high whenever at least one status bit is set and its mask bit is also set.

Most sources are level-type: after synchronization, their status bits follow the input line. Two sources are event-type. These are bit 10 (serial transmit done) and bit 11 (serial receive done). Each is latched on a rising edge of its input and cleared by software writing a 1 to it. A read-only vector register gives the index of the lowest-numbered pending source and a valid flag, so a handler can dispatch without scanning the status word.

Top module: `periph_irq_ctrl`

## Requirements
- R1: After synchronous active-low reset, the mask is zero, both event bits are zero, `irq_o` is low, and a mask or status read returns zero while all sources are low.
- R2: A write to byte address 0x0 replaces the whole mask register. A read of 0x0 in a later cycle returns the written value.
- R3: A level-type status bit (every bit except 10 and 11) equals its source line. The status bit changes on the second rising clock edge after the line changes.
- R4: Status bits 10 and 11 are set on the third rising clock edge after a rising edge of their source. They stay set after the source returns low.
- R5: A write to status address 0x4 clears bit 10 or 11 where the written data bit is 1. A written 0 leaves that event bit as it is. A status write has no effect on any other bit.
- R6: If a new source rising edge reaches an event bit in the same cycle as a clearing write to that bit, the bit stays set.
- R7: `irq_o` is high exactly when the bitwise AND of status and mask is nonzero. A mask of zero holds `irq_o` low.
- R8: A read of address 0x8 returns the lowest-numbered index set in (status AND mask) in bits [4:0], with bit 31 set to 1 as the valid flag. The read returns all zeros when nothing is pending. Writes to 0x8 are ignored.
- R9: A write to any address other than 0x0 and 0x4 changes no register. A read from an address other than 0x0, 0x4 and 0x8 returns zero.
- R10: Read data appears on `bus_rdata` after the rising clock edge at which `bus_rd` is sampled high. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 32 | Peripheral interrupt lines, asynchronous |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Results become due at different depths:
- A register write is visible to a read in the next cycle.
- Read data is due just after the edge that samples the read strobe.
- A level source reaches status and `irq_o` on the second edge after it changes.
- An event source reaches status and `irq_o` on the third edge after its rising edge.

The bench drives inputs on the falling edge. A scoreboard monitor pops the expected read value a moment after each sampling edge. Direct `irq_o` checks are placed one edge before and one edge at the due edge, so an extra or missing pipeline stage shows up. The set-versus-clear collision is timed so that the clearing write and the latch edge fall on the same edge.

// File: rtl/pirq_pkg.sv
// Shared constants and types for the peripheral interrupt controller.
// Assumes a byte-addressed register bus with word-aligned registers.
package pirq_pkg;
    // Register offsets (byte addresses)
    localparam logic [7:0] OFF_MASK = 8'h00;
    localparam logic [7:0] OFF_STAT = 8'h04;
    localparam logic [7:0] OFF_VEC  = 8'h08;

    // Decoded register selection
    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_STAT = 2'd1,
        SEL_VEC  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/pirq_src_capture.sv
// Source capture: synchronizes every interrupt line through SYNC_STAGES flops.
// Level-type bits pass the synchronized level straight to status; bits selected
// by EVT_SEL latch on a rising edge and clear on a write-one strobe.
// Assumes clr_i is already qualified by a status-register write.
module pirq_src_capture #(
    parameter int          NUM_SRC     = 32,
    parameter int          SYNC_STAGES = 2,
    parameter logic [NUM_SRC-1:0] EVT_SEL = 32'h0000_0C00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] status_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [NUM_SRC-1:0] sync_q [SYNC_STAGES];
    logic [NUM_SRC-1:0] prev_q;
    logic [NUM_SRC-1:0] evt_q;
    logic [NUM_SRC-1:0] rise;

    // First synchronizer stage samples the raw lines
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= '0;
        else        sync_q[0] <= src_i;
    end

    // Remaining synchronizer stages
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[s] <= '0;
            else        sync_q[s] <= sync_q[s-1];
        end
    end

    // Previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_q[LAST];
    end

    // Rising edges of the synchronized lines
    always_comb rise = sync_q[LAST] & ~prev_q;

    // Event latches: a new edge wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= ((evt_q & ~clr_i) | rise) & EVT_SEL;
    end

    // Status word: latched bits for events, live synchronized level otherwise
    always_comb status_o = (evt_q & EVT_SEL) | (sync_q[LAST] & ~EVT_SEL);

    // R6
    evt_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise & EVT_SEL)) |=> ((evt_q & $past(rise & EVT_SEL)) == $past(rise & EVT_SEL)));

    // R5
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~rise & EVT_SEL)) |=> ((evt_q & $past(clr_i & ~rise & EVT_SEL)) == '0));

    // R4
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_q & ~clr_i)) |=> ((evt_q & $past(evt_q & ~clr_i)) == $past(evt_q & ~clr_i)));
endmodule

// File: rtl/pirq_lowest_find.sv
// Lowest-set-bit finder: returns the index of the lowest set bit of pend_i
// and a valid flag. Purely combinational; assumes NUM_SRC >= 2.
module pirq_lowest_find #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic               valid_o
);
    // Scan from the top so the lowest set bit is written last
    always_comb begin
        idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IDX_W'(i);
        end
        valid_o = |pend_i;
    end
endmodule

// File: rtl/pirq_regs.sv
// Register file and bus decode: holds the mask, turns status writes into
// clear strobes, and returns registered read data. Assumes DATA_W >= NUM_SRC
// and that the vector word places the valid flag in its top bit.
module pirq_regs
    import pirq_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [IDX_W-1:0]   vec_idx_i,
    input  logic               vec_valid_i,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] clr_o
);
    reg_sel_e           sel;
    logic [NUM_SRC-1:0] mask_q;
    logic [DATA_W-1:0]  rd_word;

    // Address decode
    always_comb begin
        if      (bus_addr == ADDR_W'(OFF_MASK)) sel = SEL_MASK;
        else if (bus_addr == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
        else if (bus_addr == ADDR_W'(OFF_VEC))  sel = SEL_VEC;
        else                                    sel = SEL_NONE;
    end

    // Mask register: whole-word replace on write
    always_ff @(posedge clk) begin
        if (!rst_n)                        mask_q <= '0;
        else if (bus_wr && sel == SEL_MASK) mask_q <= bus_wdata[NUM_SRC-1:0];
    end

    // Write-one-to-clear strobes toward the capture stage
    always_comb clr_o = (bus_wr && sel == SEL_STAT) ? bus_wdata[NUM_SRC-1:0] : '0;

    // Read multiplexer
    always_comb begin
        rd_word = '0;
        case (sel)
            SEL_MASK: rd_word[NUM_SRC-1:0] = mask_q;
            SEL_STAT: rd_word[NUM_SRC-1:0] = status_i;
            SEL_VEC: if (vec_valid_i) begin
                rd_word[IDX_W-1:0]  = vec_idx_i;
                rd_word[DATA_W-1]   = 1'b1;
            end
            default:  rd_word = '0;
        endcase
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end

    always_comb mask_o = mask_q;

    // R2
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_MASK) |=> (mask_q == $past(bus_wdata[NUM_SRC-1:0])));

    // R9
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel != SEL_MASK) |=> $stable(mask_q));

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_NONE) |=> (bus_rdata == '0));
endmodule

// File: rtl/periph_irq_ctrl.sv
// Peripheral interrupt controller top: combines source capture, register
// file and lowest-pending finder; drives one interrupt request.
// Assumes src_i lines are asynchronous to clk.
module periph_irq_ctrl #(
    parameter int NUM_SRC     = 32,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter logic [NUM_SRC-1:0] EVT_SEL = 32'h0000_0C00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o
);
    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] mask;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] pending;
    logic [IDX_W-1:0]   vec_idx;
    logic               vec_valid;

    pirq_src_capture #(
        .NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES), .EVT_SEL(EVT_SEL)
    ) u_capture (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .clr_i(clr), .status_o(status)
    );

    pirq_regs #(
        .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .status_i(status), .vec_idx_i(vec_idx), .vec_valid_i(vec_valid),
        .mask_o(mask), .clr_o(clr)
    );

    // Pending set: enabled and asserted sources
    always_comb pending = status & mask;

    pirq_lowest_find #(.NUM_SRC(NUM_SRC)) u_find (
        .pend_i(pending), .idx_o(vec_idx), .valid_o(vec_valid)
    );

    // Interrupt request to the processor
    always_comb irq_o = |pending;

    // R8
    vec_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (pending[vec_idx] &&
            ((pending & ((NUM_SRC'(1) << vec_idx) - NUM_SRC'(1))) == '0)));

    // R7
    irq_vs_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o == vec_valid));

    // R7
    mask_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_o);
endmodule

// File: tb/periph_irq_ctrl_bench.sv
`timescale 1ns/1ps
module periph_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    periph_irq_ctrl u_periph_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // Monitor: after each sampling edge with a read, compare against scoreboard
    always @(posedge clk) begin
        if (bus_rd) begin
            #1;
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL R10: unexpected read, actual %h expected none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                compared++;
                if (bus_rdata !== e) begin
                    mismatched++;
                    $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    // Driver: register write taking effect at the next rising edge
    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: push expected word, then issue a read
    task automatic rd_reg(input logic [3:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        compared++;
        if (irq_o !== e) begin
            mismatched++;
            $display("FAIL %s: irq_o actual %b expected %b", t, irq_o, e);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #500000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_irq(1'b0, "R1");
        rd_reg(4'h0, 32'h0, "R1");
        rd_reg(4'h4, 32'h0, "R1");

        // R2 mask read-back
        wr_reg(4'h0, 32'hFFFF_FFFF);
        rd_reg(4'h0, 32'hFFFF_FFFF, "R2");
        wr_reg(4'h0, 32'h0000_00F0);
        rd_reg(4'h0, 32'h0000_00F0, "R2");

        // R3 level latency: visible on second edge
        @(negedge clk); src_i[5] = 1'b1;
        @(negedge clk); chk_irq(1'b0, "R3");
        @(negedge clk); chk_irq(1'b1, "R3");
        rd_reg(4'h4, 32'h0000_0020, "R3");
        // R8 lowest pending among enabled
        src_i[7] = 1'b1; src_i[3] = 1'b1;
        idle(3);
        rd_reg(4'h8, 32'h8000_0005, "R8");
        wr_reg(4'h0, 32'hFFFF_FFFF);
        rd_reg(4'h8, 32'h8000_0003, "R8");
        // R3 level bits fall with the line
        @(negedge clk); src_i = '0;
        @(negedge clk); chk_irq(1'b1, "R3");
        @(negedge clk); chk_irq(1'b0, "R3");
        rd_reg(4'h4, 32'h0, "R3");

        // R4 event latch on bit 10, third edge
        wr_reg(4'h0, 32'h0000_0400);
        @(negedge clk); src_i[10] = 1'b1;
        @(negedge clk); src_i[10] = 1'b0; chk_irq(1'b0, "R4");
        @(negedge clk); chk_irq(1'b0, "R4");
        @(negedge clk); chk_irq(1'b1, "R4");
        idle(4);
        chk_irq(1'b1, "R4");
        rd_reg(4'h4, 32'h0000_0400, "R4");

        // R5 zero write keeps, all-ones clears only event bits
        wr_reg(4'h0, 32'h0000_0401);
        src_i[0] = 1'b1;
        idle(3);
        wr_reg(4'h4, 32'h0000_0000);
        rd_reg(4'h4, 32'h0000_0401, "R5");
        wr_reg(4'h4, 32'hFFFF_FFFF);
        rd_reg(4'h4, 32'h0000_0001, "R5");
        src_i[0] = 1'b0;
        idle(3);
        rd_reg(4'h4, 32'h0, "R5");

        // R6 set wins over clear in the same cycle (bit 11)
        @(negedge clk); src_i[11] = 1'b1;
        @(negedge clk); src_i[11] = 1'b0;
        idle(4);
        rd_reg(4'h4, 32'h0000_0800, "R6");
        @(negedge clk); src_i[11] = 1'b1;
        @(negedge clk); src_i[11] = 1'b0;
        @(negedge clk); bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h0000_0800;
        @(negedge clk); bus_wr = 1'b0;
        rd_reg(4'h4, 32'h0000_0800, "R6");

        // R7 mask zero silences everything
        wr_reg(4'h0, 32'hFFFF_FFFF);
        @(negedge clk); chk_irq(1'b1, "R7");
        wr_reg(4'h0, 32'h0);
        chk_irq(1'b0, "R7");
        // R8 nothing pending gives zero vector; write to vector ignored
        rd_reg(4'h8, 32'h0, "R8");
        wr_reg(4'h8, 32'hFFFF_FFFF);
        rd_reg(4'h0, 32'h0, "R8");

        // R9 unmapped write/read
        wr_reg(4'h0, 32'h1234_5678);
        wr_reg(4'hC, 32'hFFFF_FFFF);
        rd_reg(4'h0, 32'h1234_5678, "R9");
        rd_reg(4'hC, 32'h0, "R9");
        // R10 read data holds between reads
        idle(3);
        compared++;
        if (bus_rdata !== 32'h0) begin
            mismatched++;
            $display("FAIL R10: held rdata actual %h expected %h", bus_rdata, 32'h0);
        end

        idle(2);
        report();
    end
endmodule